// File: doc/BRIEF.md
# Display Window Beam Comparator

This block decides, on every clock, whether the raster beam lies inside a rectangular display window. Two write-only corner registers hold the top-left (start) and bottom-right (stop) corners. Each register is 16 bits wide and keeps only the low eight bits of the vertical and horizontal coordinates. The ninth bit of each coordinate is never stored. It is rebuilt from fixed rules when the register is read out to the comparators.

The beam counters arrive as 9-bit horizontal and vertical positions. The block returns three registered flags: horizontal in range, vertical in range, and window active. The vertical flag also serves as the vertical gate for bitplane data fetch, because the fetch uses the same vertical limits as the window. The beam counters, the horizontal fetch timing and the pixel shifters belong to neighbouring blocks.

Top module: `dwin_cmp_top`

## Requirements
- R1: In a write to either corner register, `wr_data[15:8]` is the low eight bits of the vertical coordinate and `wr_data[7:0]` is the low eight bits of the horizontal coordinate.
- R2: The start corner's rebuilt ninth bit is 0 for both the vertical and the horizontal coordinate.
- R3: The stop corner's rebuilt horizontal ninth bit is always 1.
- R4: The stop corner's rebuilt vertical ninth bit is the inverse of stored vertical bit 7 (`wr_data[15]`).
- R5: `in_hrange` is 1 exactly one clock after a cycle in which start_h <= `beam_h` < stop_h. The start bound is inclusive and the stop bound is exclusive, both as 9-bit unsigned values.
- R6: `in_vrange` is 1 exactly one clock after a cycle in which start_v <= `beam_v` < stop_v. This flag is also the vertical fetch gate.
- R7: `win_active` is 1 exactly one clock after a cycle in which both the horizontal and the vertical conditions hold.
- R8: A write latches at the clock edge. A compare in the same cycle as the write still uses the old corner, and the compare in the next cycle uses the new one. A register that is not strobed keeps its value.
- R9: While `rst_n` is low, all three outputs are 0. The start corner resets to 16'hFFFF and the stop corner to 16'h8000, so the vertical range is empty and `win_active` stays 0 until a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_start | input | 1 | Write strobe for the start (top-left) corner |
| wr_stop | input | 1 | Write strobe for the stop (bottom-right) corner |
| wr_data | input | 16 | Corner data: vertical in 15:8, horizontal in 7:0 |
| beam_h | input | 9 | Horizontal beam position |
| beam_v | input | 9 | Vertical beam position |
| in_hrange | output | 1 | Registered horizontal in-range flag |
| in_vrange | output | 1 | Registered vertical in-range flag, also the fetch vertical gate |
| win_active | output | 1 | Registered display-window-active flag |

## Verification
A corner write and a boundary compare can land in the same cycle. In that case the compare must use the old corner, and the new corner must govern only the following compare. The bench provokes this with directed steps: it writes a start corner that moves the horizontal bound past the current beam while holding the beam fixed, and checks both the write cycle and the cycle after it. Random writes mixed with random beam positions repeat the collision many times. A bench model judges every cycle by applying the write only after it computes that cycle's expected flags.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam int COORD_W = 9;
  localparam int FIELD_W = COORD_W - 1;
  localparam int REG_W   = 2 * FIELD_W;

  typedef enum logic {CORNER_START = 1'b0, CORNER_STOP = 1'b1} corner_kind_e;

  typedef struct packed {
    logic [COORD_W-1:0] v;
    logic [COORD_W-1:0] h;
  } corner_t;
endpackage

// File: rtl/dwin_corner.sv
module dwin_corner
  import dwin_pkg::*;
#(
  parameter corner_kind_e        KIND    = CORNER_START,
  parameter logic [REG_W-1:0]    RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output corner_t          pos
);
  logic [REG_W-1:0]   raw_q;
  logic [REG_W-1:0]   raw_d;
  logic [FIELD_W-1:0] f_v;
  logic [FIELD_W-1:0] f_h;

  // next state: load on strobe, otherwise hold
  always_comb begin
    raw_d = raw_q;
    if (wr_en) raw_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= RST_VAL;
    else        raw_q <= raw_d;
  end

  assign f_v = raw_q[REG_W-1:FIELD_W];
  assign f_h = raw_q[FIELD_W-1:0];

  // rebuild the ninth bit from the fixed per-corner rules
  generate
    if (KIND == CORNER_START) begin : g_start
      assign pos.v = {1'b0, f_v};
      assign pos.h = {1'b0, f_h};
    end else begin : g_stop
      assign pos.v = {~f_v[FIELD_W-1], f_v};
      assign pos.h = {1'b1, f_h};
    end
  endgenerate
endmodule

// File: rtl/dwin_axis_cmp.sv
module dwin_axis_cmp #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit_d,
  output logic         hit_q
);
  logic ge_lo;
  logic lt_hi;

  always_comb begin
    ge_lo = (pos >= lo);
    lt_hi = (pos < hi);
    hit_d = ge_lo & lt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end
endmodule

// File: rtl/dwin_cmp_top.sv
module dwin_cmp_top
  import dwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_start,
  input  logic               wr_stop,
  input  logic [15:0]        wr_data,
  input  logic [8:0]         beam_h,
  input  logic [8:0]         beam_v,
  output logic               in_hrange,
  output logic               in_vrange,
  output logic               win_active
);
  corner_t start_pos;
  corner_t stop_pos;
  logic    h_hit_d;
  logic    v_hit_d;
  logic    win_d;
  logic    win_q;

  dwin_corner #(.KIND(CORNER_START), .RST_VAL(16'hFFFF)) u_start (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_start), .wr_data(wr_data), .pos(start_pos)
  );

  dwin_corner #(.KIND(CORNER_STOP), .RST_VAL(16'h8000)) u_stop (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stop), .wr_data(wr_data), .pos(stop_pos)
  );

  dwin_axis_cmp #(.W(COORD_W)) u_hcmp (
    .clk(clk), .rst_n(rst_n), .pos(beam_h), .lo(start_pos.h), .hi(stop_pos.h),
    .hit_d(h_hit_d), .hit_q(in_hrange)
  );

  dwin_axis_cmp #(.W(COORD_W)) u_vcmp (
    .clk(clk), .rst_n(rst_n), .pos(beam_v), .lo(start_pos.v), .hi(stop_pos.v),
    .hit_d(v_hit_d), .hit_q(in_vrange)
  );

  always_comb win_d = h_hit_d & v_hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign win_active = win_q;
endmodule

// File: rtl/dwin_chk.sv
module dwin_chk
  import dwin_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_start,
  input logic        wr_stop,
  input logic [15:0] wr_data,
  input logic [8:0]  beam_h,
  input logic [8:0]  beam_v,
  input logic        in_hrange,
  input logic        in_vrange,
  input logic        win_active,
  input corner_t     start_pos,
  input corner_t     stop_pos
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_win_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> (in_hrange && in_vrange));

  assert_hrange_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (in_hrange == (($past(beam_h) >= $past(start_pos.h)) &&
                             ($past(beam_h) <  $past(stop_pos.h)))));

  assert_vrange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (in_vrange == (($past(beam_v) >= $past(start_pos.v)) &&
                             ($past(beam_v) <  $past(stop_pos.v)))));

  assert_start_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (start_pos.v[7:0] == $past(wr_data[15:8]) &&
                  start_pos.h[7:0] == $past(wr_data[7:0])));

  assert_stop_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |=> (stop_pos.v[7:0] == $past(wr_data[15:8]) &&
                 stop_pos.h[7:0] == $past(wr_data[7:0])));

  assert_start_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_start |=> $stable(start_pos));

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stop |=> $stable(stop_pos));
endmodule

bind dwin_cmp_top dwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_stop(wr_stop),
  .wr_data(wr_data), .beam_h(beam_h), .beam_v(beam_v),
  .in_hrange(in_hrange), .in_vrange(in_vrange), .win_active(win_active),
  .start_pos(start_pos), .stop_pos(stop_pos)
);

// File: tb/sim_dwin_cmp_top.sv
module sim_dwin_cmp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_start, wr_stop;
  logic [15:0] wr_data;
  logic [8:0]  beam_h, beam_v;
  logic        in_hrange, in_vrange, win_active;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_st = 16'hFFFF;
  logic [15:0] m_sp = 16'h8000;

  always #10 clk = ~clk;

  dwin_cmp_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_stop(wr_stop),
    .wr_data(wr_data), .beam_h(beam_h), .beam_v(beam_v),
    .in_hrange(in_hrange), .in_vrange(in_vrange), .win_active(win_active)
  );

  // expected {win, v, h} from corner words and beam (R1..R4 rules)
  function automatic logic [2:0] expect_out(logic [15:0] s, logic [15:0] p,
                                            logic [8:0] h, logic [8:0] v);
    logic [8:0] sh, sv, ph, pv;
    logic hr, vr;
    sh = {1'b0, s[7:0]};
    sv = {1'b0, s[15:8]};
    ph = {1'b1, p[7:0]};
    pv = {~p[15], p[15:8]};
    hr = (h >= sh) && (h < ph);
    vr = (v >= sv) && (v < pv);
    return {hr && vr, vr, hr};
  endfunction

  task automatic chk(string req, logic act, logic ex);
    n_cmp++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, ex);
    end
  endtask

  // called at a negedge; drives one cycle and checks the flags one clock later
  task automatic step(logic ws, logic wt, logic [15:0] d,
                      logic [8:0] h, logic [8:0] v, string note);
    logic [2:0] e;
    wr_start = ws; wr_stop = wt; wr_data = d; beam_h = h; beam_v = v;
    e = expect_out(m_st, m_sp, h, v);
    if (ws) m_st = d;
    if (wt) m_sp = d;
    @(posedge clk);
    @(negedge clk);
    wr_start = 1'b0; wr_stop = 1'b0;
    chk({"R5 ", note}, in_hrange,  e[0]);
    chk({"R6 ", note}, in_vrange,  e[1]);
    chk({"R7 ", note}, win_active, e[2]);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_start = 1'b0; wr_stop = 1'b0; wr_data = '0;
    beam_h = 9'h0FF; beam_v = 9'h0FF;
    repeat (3) @(negedge clk);
    chk("R9 reset hrange", in_hrange, 1'b0);
    chk("R9 reset vrange", in_vrange, 1'b0);
    chk("R9 reset win",    win_active, 1'b0);
    rst_n = 1'b1;

    // empty window after reset
    for (int i = 0; i < 8; i++)
      step(0, 0, 16'h0, 9'(i * 64), 9'(i * 40), "R9 empty after reset");
    step(0, 0, 16'h0, 9'h0FF, 9'h0FF, "R9 empty corner beam");

    // program corners: start v=0x10 h=0x20; stop byte v=0x40 -> v=0x140, h=0x130
    step(1, 0, 16'h1020, 9'h000, 9'h000, "R1 R2 start write");
    step(0, 1, 16'h4030, 9'h000, 9'h000, "R1 R4 stop write");
    step(0, 0, 16'h0, 9'h120, 9'h120, "R2 R3 R4 inside");
    step(0, 0, 16'h0, 9'h130, 9'h120, "R3 h stop exclusive");
    step(0, 0, 16'h0, 9'h12F, 9'h120, "R3 h last inside");
    step(0, 0, 16'h0, 9'h020, 9'h120, "R2 h start inclusive");
    step(0, 0, 16'h0, 9'h01F, 9'h120, "R2 h before start");
    step(0, 0, 16'h0, 9'h120, 9'h13F, "R4 v last inside");
    step(0, 0, 16'h0, 9'h120, 9'h140, "R4 v stop exclusive");
    step(0, 0, 16'h0, 9'h120, 9'h010, "R2 v start inclusive");
    step(0, 0, 16'h0, 9'h120, 9'h00F, "R2 v before start");

    // stop v byte with bit7 set -> ninth bit 0, stop v = 0x0C0
    step(0, 1, 16'hC030, 9'h120, 9'h020, "R4 stop rewrite");
    step(0, 0, 16'h0, 9'h120, 9'h100, "R4 v above low stop");
    step(0, 0, 16'h0, 9'h120, 9'h0BF, "R4 v below low stop");

    // write colliding with a boundary compare
    step(1, 0, 16'h5050, 9'h030, 9'h060, "R8 write cycle uses old corner");
    step(0, 0, 16'h0,    9'h030, 9'h060, "R8 next compare uses new corner");
    step(0, 0, 16'h0,    9'h050, 9'h060, "R8 new start inclusive");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic ws, wt;
      logic [15:0] d;
      ws = ($urandom % 8) == 0;
      wt = ($urandom % 8) == 0;
      d  = 16'($urandom);
      step(ws, wt, d, 9'($urandom), 9'($urandom), "R8 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule